// File: doc/BRIEF.md
# Counting Interrupt Controller

This block gathers up to 32 level-type interrupt lines into two processor request outputs: a normal request and a fast request. Each source has a latched level bit. A rising input sets its bit and a falling input clears it. A bit for an input that holds its value does not change. The normal request is raised when any latched source is also enabled in the normal mask. The fast request is raised when any latched source is set in a fast mask. That fast mask comes from a static configuration input and is not written over the bus.

Software sees the controller through a small register window on a one-cycle request bus. One offset returns how many enabled sources are pending. A second offset returns the index of the lowest-numbered pending enabled source. Single sources are enabled or disabled by writing their index to a command offset. One more command drops every latched level at once and leaves both masks as they were. A source is re-latched only on a fresh rising input.

Top module: `pend_count_intc`

## Requirements
- R1: In reset and right after it, the level bits, the normal mask and the pending count are zero, both request outputs are low and every read returns zero.
- R2: A 0-to-1 change on an input sets its level bit and a 1-to-0 change clears it. An input held at one value leaves its bit alone. Any number of inputs may change in one cycle.
- R3: A read of offset 0x000 returns popcount(level AND normal mask). This holds across simultaneous input changes and mask writes.
- R4: A read of offset 0x004 returns the lowest index set in (level AND normal mask), or 0 when that set is empty.
- R5: A write of value N below the source count to offset 0x010 sets normal-mask bit N. The same write to offset 0x00C clears it. The new mask takes part in the count and the index from the next cycle.
- R6: Any write to offset 0x008 clears every level bit, which brings the count to zero. The normal mask is unchanged, and a source that stays high is not re-latched until it falls and rises again.
- R7: The normal request equals OR(level AND normal mask). The fast request equals OR(level AND fast mask), where the fast mask follows the configuration input. Both are updated in the cycle after the change that causes them.
- R8: A write to offset 0x000, 0x004 or an unmapped offset is ignored. An enable or disable value of 32 or more is ignored. A read from any offset other than 0x000 and 0x004 returns zero.
- R9: Read data is registered. It appears in the cycle after the read request and is zero in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Level interrupt inputs, one per source |
| fiqMaskCfg | input | 32 | Static fast-request mask |
| busValid | input | 1 | Bus request in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset within the 4 KiB window |
| busWdata | input | 32 | Write data (source index for the mask commands) |
| busRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
Sources are raised one at a time and also together in the same cycle, including both ends of the index range (0 and 31). This separates a count kept correctly from one that misses simultaneous changes, and shows whether the index search picks the lowest bit or the highest. Sources that are latched but masked, then enabled, then disabled, show whether the count follows the mask as well as the inputs. A line is held high through a clear-all, then dropped and raised again. This tells level following apart from edge latching, and shows that the mask survives the clear. Out-of-range indices and writes to read-only offsets are placed between reads to show that they leave the state unchanged.

// File: rtl/pcic_pkg.sv
package pcic_pkg;
  localparam logic [11:0] OFS_COUNT   = 12'h000;
  localparam logic [11:0] OFS_INDEX   = 12'h004;
  localparam logic [11:0] OFS_CLEAR   = 12'h008;
  localparam logic [11:0] OFS_DISABLE = 12'h00C;
  localparam logic [11:0] OFS_ENABLE  = 12'h010;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_COUNT = 2'd1,
    RD_INDEX = 2'd2,
    RD_ZERO  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   clearAll;
    logic   enableStb;
    logic   disableStb;
    rdSel_e rdSel;
  } ctlStb_t;
endpackage

// File: rtl/pcic_ctrl.sv
module pcic_ctrl
  import pcic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctlStb_t           stb,
  output logic [IDX_W-1:0]  selIdx
);
  logic idxOk;
  logic isWrite;
  logic isRead;

  assign idxOk   = busWdata < DATA_W'(NUM_SRC);
  assign isWrite = busValid && busWrite;
  assign isRead  = busValid && !busWrite;
  assign selIdx  = busWdata[IDX_W-1:0];

  always_comb begin
    stb = '{clearAll: 1'b0, enableStb: 1'b0, disableStb: 1'b0, rdSel: RD_NONE};
    if (isWrite) begin
      if (busAddr == ADDR_W'(OFS_CLEAR)) begin
        stb.clearAll = 1'b1;
      end else if (busAddr == ADDR_W'(OFS_DISABLE)) begin
        stb.disableStb = idxOk;
      end else if (busAddr == ADDR_W'(OFS_ENABLE)) begin
        stb.enableStb = idxOk;
      end
    end else if (isRead) begin
      if (busAddr == ADDR_W'(OFS_COUNT)) begin
        stb.rdSel = RD_COUNT;
      end else if (busAddr == ADDR_W'(OFS_INDEX)) begin
        stb.rdSel = RD_INDEX;
      end else begin
        stb.rdSel = RD_ZERO;
      end
    end
  end
endmodule

// File: rtl/pcic_datapath.sv
module pcic_datapath
  import pcic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int CNT_W  = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] fiqMaskCfg,
  input  ctlStb_t            stb,
  input  logic [IDX_W-1:0]   selIdx,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [NUM_SRC-1:0] levelQ,
  output logic [NUM_SRC-1:0] irqEnQ
);
  logic [NUM_SRC-1:0] prevIn;
  logic [NUM_SRC-1:0] fiqEnQ;
  logic [CNT_W-1:0]   countQ;
  logic [NUM_SRC-1:0] levelNext;
  logic [NUM_SRC-1:0] enNext;
  logic [NUM_SRC-1:0] selMask;
  logic [NUM_SRC-1:0] pendVec;
  logic [CNT_W-1:0]   countNext;
  logic [IDX_W-1:0]   lowIdx;
  logic [DATA_W-1:0]  rdNext;

  // per-source level latch: rise sets, fall clears, clear-all drops the old value
  for (genvar g = 0; g < NUM_SRC; g++) begin : gLevel
    logic riseBit;
    logic fallBit;
    logic baseBit;
    assign riseBit      = srcIn[g] && !prevIn[g];
    assign fallBit      = !srcIn[g] && prevIn[g];
    assign baseBit      = stb.clearAll ? 1'b0 : levelQ[g];
    assign levelNext[g] = (baseBit || riseBit) && !fallBit;
  end

  assign selMask = NUM_SRC'(1) << selIdx;

  always_comb begin
    enNext = irqEnQ;
    if (stb.enableStb) begin
      enNext = irqEnQ | selMask;
    end else if (stb.disableStb) begin
      enNext = irqEnQ & ~selMask;
    end
  end

  always_comb begin
    logic [NUM_SRC-1:0] nextPend;
    nextPend  = levelNext & enNext;
    countNext = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      countNext = countNext + CNT_W'(nextPend[i]);
    end
  end

  assign pendVec = levelQ & irqEnQ;

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) lowIdx = IDX_W'(i);
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_COUNT: rdNext = DATA_W'(countQ);
      RD_INDEX: rdNext = DATA_W'(lowIdx);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn <= '0;
      levelQ <= '0;
      irqEnQ <= '0;
      fiqEnQ <= '0;
      countQ <= '0;
      rdData <= '0;
    end else begin
      prevIn <= srcIn;
      levelQ <= levelNext;
      irqEnQ <= enNext;
      fiqEnQ <= fiqMaskCfg;
      countQ <= countNext;
      rdData <= rdNext;
    end
  end

  assign irqOut = |pendVec;
  assign fiqOut = |(levelQ & fiqEnQ);
endmodule

// File: rtl/pend_count_intc.sv
module pend_count_intc
  import pcic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] fiqMaskCfg,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic               fiqOut
);
  localparam int IDX_W = $clog2(NUM_SRC);

  ctlStb_t            stb;
  logic [IDX_W-1:0]   selIdx;
  logic [NUM_SRC-1:0] levelQ;
  logic [NUM_SRC-1:0] irqEnQ;

  pcic_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .stb     (stb),
    .selIdx  (selIdx)
  );

  pcic_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .fiqMaskCfg(fiqMaskCfg),
    .stb       (stb),
    .selIdx    (selIdx),
    .rdData    (busRdata),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut),
    .levelQ    (levelQ),
    .irqEnQ    (irqEnQ)
  );
endmodule

// File: rtl/pcic_chk.sv
module pcic_chk
  import pcic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] levelQ,
  input logic [NUM_SRC-1:0] irqEnQ
);
  // R9
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> busRdata == '0);

  // R3
  count_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == ADDR_W'(OFS_COUNT))
      |=> busRdata == DATA_W'($countones($past(levelQ & irqEnQ))));

  // R4
  index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == ADDR_W'(OFS_INDEX))
      |=> busRdata < DATA_W'(NUM_SRC));

  // R5
  enable_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == ADDR_W'(OFS_ENABLE) && busWdata < DATA_W'(NUM_SRC))
      |=> irqEnQ[$past(busWdata[IDX_W-1:0])]);

  // R6
  clear_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == ADDR_W'(OFS_CLEAR)) |=> $stable(irqEnQ));

  // R8
  bad_index_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busWdata >= DATA_W'(NUM_SRC)) |=> $stable(irqEnQ));

  // R7
  no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnQ == '0) |-> !irqOut);
endmodule

bind pend_count_intc pcic_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busValid(busValid),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .levelQ  (levelQ),
  .irqEnQ  (irqEnQ)
);

// File: tb/pend_count_intc_test.sv
`timescale 1ns/1ps
module pend_count_intc_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [31:0] fiqMaskCfg = '0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic        fiqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit started = 0;

  // behavioural reference state
  bit  mLevel[32];
  bit  mEn[32];
  bit  mFiq[32];
  bit  mPrev[32];
  int  mRd = 0;
  int  lastRdAddr = -1;

  always #10 clk = ~clk;

  pend_count_intc uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .fiqMaskCfg(fiqMaskCfg),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  function automatic int modelCount();
    int c = 0;
    for (int i = 0; i < 32; i++) if (mLevel[i] && mEn[i]) c++;
    return c;
  endfunction

  function automatic int modelLowest();
    for (int i = 0; i < 32; i++) if (mLevel[i] && mEn[i]) return i;
    return 0;
  endfunction

  function automatic bit modelIrq();
    return modelCount() != 0;
  endfunction

  function automatic bit modelFiq();
    for (int i = 0; i < 32; i++) if (mLevel[i] && mFiq[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      for (int i = 0; i < 32; i++) begin
        mLevel[i] = 0; mEn[i] = 0; mFiq[i] = 0; mPrev[i] = 0;
      end
      mRd = 0;
      lastRdAddr = -1;
    end else begin
      mRd = 0;
      lastRdAddr = -1;
      if (busValid && !busWrite) begin
        lastRdAddr = int'(busAddr);
        if (busAddr == 12'h000) mRd = modelCount();
        else if (busAddr == 12'h004) mRd = modelLowest();
      end
      if (busValid && busWrite) begin
        if (busAddr == 12'h008) begin
          for (int i = 0; i < 32; i++) mLevel[i] = 0;
        end else if (busAddr == 12'h010 && busWdata < 32) begin
          mEn[busWdata] = 1;
        end else if (busAddr == 12'h00C && busWdata < 32) begin
          mEn[busWdata] = 0;
        end
      end
      for (int i = 0; i < 32; i++) begin
        if (srcIn[i] && !mPrev[i]) mLevel[i] = 1;
        if (!srcIn[i] && mPrev[i]) mLevel[i] = 0;
        mPrev[i] = srcIn[i];
        mFiq[i] = fiqMaskCfg[i];
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      check("R7 irqOut", int'(irqOut), int'(modelIrq()));
      check("R7 fiqOut", int'(fiqOut), int'(modelFiq()));
      if (lastRdAddr == 0)      check("R3 count read", int'(busRdata), mRd);
      else if (lastRdAddr == 4) check("R4 index read", int'(busRdata), mRd);
      else if (lastRdAddr >= 0) check("R8 zero read", int'(busRdata), mRd);
      else                      check("R9 idle rdata", int'(busRdata), mRd);
    end
  end

  task automatic busWr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic busRd(logic [11:0] a, int exp, string tag);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busValid = 0;
    check(tag, int'(busRdata), exp);
  endtask

  task automatic setSrc(logic [31:0] v);
    @(negedge clk);
    srcIn = v;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", int'(irqOut), 0);
    check("R1 fiq in reset", int'(fiqOut), 0);
    rstN = 1;
    busRd(12'h000, 0, "R1 count after reset");
    busRd(12'h004, 0, "R1 index after reset");

    // masked sources latched, fast mask on source 8
    fiqMaskCfg = 32'h0000_0100;
    setSrc(32'h0000_0108);
    check("R7 irq with empty mask", int'(irqOut), 0);
    check("R7 fiq from cfg mask", int'(fiqOut), 1);
    busRd(12'h000, 0, "R3 masked count");

    busWr(12'h010, 3);
    busRd(12'h000, 1, "R5 enable 3 count");
    busRd(12'h004, 3, "R4 index 3");
    check("R7 irq after enable", int'(irqOut), 1);
    busWr(12'h010, 8);
    busRd(12'h000, 2, "R5 enable 8 count");
    busRd(12'h004, 3, "R4 lowest of 3,8");

    // ignored accesses
    busWr(12'h010, 40);
    busWr(12'h00C, 32);
    busWr(12'h000, 5);
    busWr(12'h004, 9);
    busWr(12'h100, 3);
    busRd(12'h000, 2, "R8 ignored writes count");
    busRd(12'h008, 0, "R8 read of command offset");
    busRd(12'h010, 0, "R8 read of enable offset");

    busWr(12'h00C, 3);
    busRd(12'h000, 1, "R5 disable 3 count");
    busRd(12'h004, 8, "R4 index after disable");

    // simultaneous rises at both ends
    setSrc(32'h8000_0109);
    busWr(12'h010, 31);
    busWr(12'h010, 0);
    busRd(12'h000, 3, "R3 count with 0,8,31");
    busRd(12'h004, 0, "R4 index 0");

    // simultaneous falls
    setSrc(32'h8000_0008);
    busRd(12'h000, 1, "R2 count after two falls");
    busRd(12'h004, 31, "R4 index 31");
    check("R7 fiq after fall", int'(fiqOut), 0);

    // clear-all with lines held high
    busWr(12'h008, 0);
    busRd(12'h000, 0, "R6 count after clear");
    check("R6 irq after clear", int'(irqOut), 0);
    repeat (3) @(negedge clk);
    busRd(12'h000, 0, "R2 held line not relatched");
    setSrc(32'h0000_0008);
    setSrc(32'h8000_0008);
    busRd(12'h000, 1, "R6 mask kept after clear");
    busRd(12'h004, 31, "R6 index after relatch");

    // registered read: data only in cycle after request
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = 12'h000;
    @(negedge clk);
    busValid = 0;
    check("R9 data one cycle later", int'(busRdata), 1);
    @(negedge clk);
    check("R9 zero after idle", int'(busRdata), 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule